// File: doc/BRIEF.md
# Receive Buffer Lock Controller

This block guards the receive message buffers of a frame controller against being overwritten while the CPU reads one of them. When the CPU reads the control/status word of a receive buffer that holds a frame, the block takes that read as the start of an atomic read of the whole buffer. It places a lock on that buffer. Only one buffer can be locked at any time. The lock ends when the CPU reads the free-running timer, or when it reads the control/status word of another buffer. That second read may lock the newly read buffer in the same cycle.

Frame matching happens elsewhere. It delivers a move-in request that names the target buffer of a frame now sitting in the serial holding buffer. The block grants the move-in one cycle after capturing it, as long as the target is not locked. If the target is locked, the frame waits in the holding buffer and is granted on the first cycle after the lock is released. A second frame that arrives while the pending frame is blocked is dropped. The block flags this as an overrun and keeps the older frame.

A compatibility bit selects which buffer codes can be locked. With the bit set, buffers coded inactive or empty are never locked. With the bit cleared, empty buffers can be locked as well, which matches an older behaviour.

Top module: `rx_buf_lock`

## Requirements
- R1: A control/status read (cpu_rd_vld=1, cpu_rd_timer=0) of receive buffer k (buf_is_tx[k]=0) whose 4-bit code is neither 4'b0000 nor 4'b0100 sets lock_vld=1 with lock_idx=k, visible the cycle after the read.
- R2: A timer read (cpu_rd_vld=1, cpu_rd_timer=1) clears lock_vld the cycle after the read.
- R3: A control/status read of a buffer other than the locked one releases the old lock; if the new buffer qualifies, it becomes the one locked buffer in the same cycle.
- R4: A buffer with buf_is_tx=1 is never locked, whatever its code; reading it releases any existing lock.
- R5: With compat_mode=1, reading a receive buffer coded 4'b0000 or 4'b0100 sets no lock and releases any existing lock.
- R6: With compat_mode=0, a receive buffer coded 4'b0100 is locked by a read, while code 4'b0000 still is not.
- R7: A move-in request sampled at clock edge n with an unlocked target makes hold_busy=1 after edge n, and makes mv_grant=1 with mv_grant_idx equal to the target for exactly the cycle after edge n+1.
- R8: While the holding frame's target equals lock_idx and lock_vld=1, mv_grant stays 0 and hold_busy stays 1.
- R9: When the blocking lock is cleared at edge n, mv_grant for the waiting frame is 1 during the cycle after edge n+1.
- R10: A move-in request that arrives while the held frame is blocked pulses overrun for one cycle, and the older frame keeps its target and is the one granted later.
- R11: After reset, lock_vld, hold_busy, mv_grant and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd_vld | input | 1 | CPU read strobe of a tracked location |
| cpu_rd_timer | input | 1 | 1: the read targets the free-running timer; 0: a control/status word |
| cpu_rd_idx | input | IDX_W | Buffer whose control/status word is read |
| buf_code | input | NUM_BUFS*CODE_W | Code field of every buffer, buffer k at bits [k*CODE_W +: CODE_W] |
| buf_is_tx | input | NUM_BUFS | Direction per buffer, 1 = transmit |
| compat_mode | input | 1 | 1: empty buffers cannot be locked; 0: they can |
| mv_req | input | 1 | New frame in the serial holding buffer wants to move in |
| mv_idx | input | IDX_W | Target buffer of the move-in request |
| lock_vld | output | 1 | A buffer is locked |
| lock_idx | output | IDX_W | Locked buffer |
| mv_grant | output | 1 | One-cycle move-in grant |
| mv_grant_idx | output | IDX_W | Buffer written by the granted move-in |
| hold_busy | output | 1 | The holding buffer has a frame that has not been granted |
| overrun | output | 1 | One-cycle pulse: a new frame was dropped |

## Verification
The hardest situation to reach from the ports is a move-in that is blocked and then overrun. This needs a lock on a buffer, a frame aimed at that same buffer, a second frame arriving while the first still waits, and then the release. The directed part of the bench sets up the lock with a control/status read and sends a move-in to the locked index. It holds the lock for several cycles, fires a second request to another index, and then releases the lock with a timer read. It checks the exact cycle of the grant and that the grant carries the older index.

// File: rtl/rx_buf_lock_pkg.sv
package rx_buf_lock_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_EMPTY    = 4'b0100;

  // Decide whether a buffer may take the read lock
  function automatic logic may_lock(input logic [CODE_W-1:0] code,
                                    input logic is_tx,
                                    input logic compat);
    logic ok;
    ok = !is_tx && (code != CODE_INACTIVE);
    if (compat && (code == CODE_EMPTY)) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/rx_buf_lock_qual.sv
module rx_buf_lock_qual
  import rx_buf_lock_pkg::*;
#(
  parameter int NUM_BUFS = 16
) (
  input  logic [NUM_BUFS*CODE_W-1:0] buf_code,
  input  logic [NUM_BUFS-1:0]        buf_is_tx,
  input  logic                       compat_mode,
  output logic [NUM_BUFS-1:0]        lockable
);
  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
    assign lockable[g] = may_lock(buf_code[g*CODE_W +: CODE_W], buf_is_tx[g], compat_mode);
  end
endmodule

// File: rtl/rx_buf_lock_reg.sv
module rx_buf_lock_reg #(
  parameter int NUM_BUFS = 16,
  localparam int IDX_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_vld,
  input  logic                rd_timer,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [NUM_BUFS-1:0] lockable,
  output logic                lock_vld,
  output logic [IDX_W-1:0]    lock_idx
);
  logic in_range;
  logic sel_ok;

  assign in_range = ({1'b0, rd_idx} < (IDX_W+1)'(NUM_BUFS));
  assign sel_ok   = in_range && lockable[rd_idx];

  // One index register: at most one buffer is ever locked
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_vld <= 1'b0;
      lock_idx <= '0;
    end else if (rd_vld) begin
      if (rd_timer) begin
        lock_vld <= 1'b0;
      end else begin
        lock_vld <= sel_ok;
        lock_idx <= rd_idx;
      end
    end
  end

  p_lock_set_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !rd_timer && sel_ok) |=> (lock_vld && lock_idx == $past(rd_idx)));
  p_timer_unlock_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && rd_timer) |=> !lock_vld);
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !rd_timer && !sel_ok) |=> !lock_vld);
  p_lock_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_vld |=> ($stable(lock_vld) && $stable(lock_idx)));
endmodule

// File: rtl/rx_buf_lock_hold.sv
module rx_buf_lock_hold #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mv_req,
  input  logic [IDX_W-1:0] mv_idx,
  input  logic             lock_vld,
  input  logic [IDX_W-1:0] lock_idx,
  output logic             hold_busy,
  output logic [IDX_W-1:0] hold_idx,
  output logic             grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             overrun
);
  logic blocked;
  logic release_now;

  assign blocked     = hold_busy && lock_vld && (lock_idx == hold_idx);
  assign release_now = hold_busy && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_busy <= 1'b0;
      hold_idx  <= '0;
      grant     <= 1'b0;
      grant_idx <= '0;
      overrun   <= 1'b0;
    end else begin
      grant   <= release_now;
      overrun <= mv_req && blocked;
      if (release_now) grant_idx <= hold_idx;
      if (mv_req && !blocked) begin
        hold_busy <= 1'b1;
        hold_idx  <= mv_idx;
      end else if (release_now) begin
        hold_busy <= 1'b0;
      end
    end
  end

  p_blocked_waits_r8: assert property (@(posedge clk) disable iff (rst)
    (hold_busy && lock_vld && lock_idx == hold_idx) |=> (!grant && hold_busy));
  p_grant_unlocked_r9: assert property (@(posedge clk) disable iff (rst)
    grant |-> !($past(lock_vld) && $past(lock_idx) == grant_idx));
  p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    overrun |-> (hold_busy && $stable(hold_idx)));
  p_grant_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (grant && !$past(mv_req)) |-> !hold_busy);
endmodule

// File: rtl/rx_buf_lock.sv
module rx_buf_lock
  import rx_buf_lock_pkg::*;
#(
  parameter int NUM_BUFS = 16,
  localparam int IDX_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_rd_vld,
  input  logic                       cpu_rd_timer,
  input  logic [IDX_W-1:0]           cpu_rd_idx,
  input  logic [NUM_BUFS*CODE_W-1:0] buf_code,
  input  logic [NUM_BUFS-1:0]        buf_is_tx,
  input  logic                       compat_mode,
  input  logic                       mv_req,
  input  logic [IDX_W-1:0]           mv_idx,
  output logic                       lock_vld,
  output logic [IDX_W-1:0]           lock_idx,
  output logic                       mv_grant,
  output logic [IDX_W-1:0]           mv_grant_idx,
  output logic                       hold_busy,
  output logic                       overrun
);
  logic [NUM_BUFS-1:0] lockable;
  logic [IDX_W-1:0]    hold_idx;

  rx_buf_lock_qual #(.NUM_BUFS(NUM_BUFS)) u_qual (
    .buf_code    (buf_code),
    .buf_is_tx   (buf_is_tx),
    .compat_mode (compat_mode),
    .lockable    (lockable)
  );

  rx_buf_lock_reg #(.NUM_BUFS(NUM_BUFS)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .rd_vld   (cpu_rd_vld),
    .rd_timer (cpu_rd_timer),
    .rd_idx   (cpu_rd_idx),
    .lockable (lockable),
    .lock_vld (lock_vld),
    .lock_idx (lock_idx)
  );

  rx_buf_lock_hold #(.IDX_W(IDX_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .mv_req    (mv_req),
    .mv_idx    (mv_idx),
    .lock_vld  (lock_vld),
    .lock_idx  (lock_idx),
    .hold_busy (hold_busy),
    .hold_idx  (hold_idx),
    .grant     (mv_grant),
    .grant_idx (mv_grant_idx),
    .overrun   (overrun)
  );

  p_tx_nolock_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_vld && !cpu_rd_timer && buf_is_tx[cpu_rd_idx]) |=> !lock_vld);
  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!lock_vld && !hold_busy && !mv_grant && !overrun));
endmodule

// File: tb/sim_rx_buf_lock.sv
module sim_rx_buf_lock;
  localparam int NB = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_rd_vld = 1'b0, cpu_rd_timer = 1'b0;
  logic [IW-1:0] cpu_rd_idx = '0;
  logic [3:0] codes [NB];
  logic [NB-1:0] is_tx = '0;
  logic [NB*4-1:0] buf_code;
  logic compat_mode = 1'b1;
  logic mv_req = 1'b0;
  logic [IW-1:0] mv_idx = '0;
  logic lock_vld, mv_grant, hold_busy, overrun;
  logic [IW-1:0] lock_idx, mv_grant_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  always_comb
    for (int k = 0; k < NB; k++) buf_code[k*4 +: 4] = codes[k];

  rx_buf_lock #(.NUM_BUFS(NB)) u0 (
    .clk(clk), .rst(rst), .cpu_rd_vld(cpu_rd_vld), .cpu_rd_timer(cpu_rd_timer),
    .cpu_rd_idx(cpu_rd_idx), .buf_code(buf_code), .buf_is_tx(is_tx),
    .compat_mode(compat_mode), .mv_req(mv_req), .mv_idx(mv_idx),
    .lock_vld(lock_vld), .lock_idx(lock_idx), .mv_grant(mv_grant),
    .mv_grant_idx(mv_grant_idx), .hold_busy(hold_busy), .overrun(overrun));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Fields: timer, idx, code, tx, compat, exp_vld, exp_idx, req number
  localparam int VW = 20;
  localparam logic [VW-1:0] VEC [13] = '{
    {1'b0, 4'd3,  4'b0010, 1'b0, 1'b1, 1'b1, 4'd3,  4'd1},  // R1 full rx buffer locks
    {1'b0, 4'd5,  4'b0100, 1'b0, 1'b1, 1'b0, 4'd0,  4'd5},  // R5 empty, releases 3
    {1'b0, 4'd5,  4'b0010, 1'b0, 1'b1, 1'b1, 4'd5,  4'd1},  // R1
    {1'b0, 4'd7,  4'b0000, 1'b0, 1'b1, 1'b0, 4'd0,  4'd5},  // R5 inactive
    {1'b0, 4'd2,  4'b0110, 1'b0, 1'b1, 1'b1, 4'd2,  4'd1},  // R1 other active code
    {1'b1, 4'd0,  4'b0000, 1'b0, 1'b1, 1'b0, 4'd0,  4'd2},  // R2 timer read
    {1'b0, 4'd4,  4'b0100, 1'b0, 1'b0, 1'b1, 4'd4,  4'd6},  // R6 empty locks
    {1'b0, 4'd9,  4'b0000, 1'b0, 1'b0, 1'b0, 4'd0,  4'd6},  // R6 inactive never
    {1'b0, 4'd1,  4'b0010, 1'b0, 1'b1, 1'b1, 4'd1,  4'd1},  // R1
    {1'b0, 4'd6,  4'b1010, 1'b1, 1'b1, 1'b0, 4'd0,  4'd4},  // R4 tx buffer
    {1'b0, 4'd8,  4'b0010, 1'b0, 1'b1, 1'b1, 4'd8,  4'd1},  // R1
    {1'b0, 4'd15, 4'b0110, 1'b0, 1'b1, 1'b1, 4'd15, 4'd3},  // R3 lock moves 8 -> 15
    {1'b1, 4'd0,  4'b0000, 1'b0, 1'b1, 1'b0, 4'd0,  4'd2}   // R2
  };

  task automatic cs_read(input logic tmr, input logic [IW-1:0] idx);
    @(negedge clk);
    cpu_rd_vld = 1'b1; cpu_rd_timer = tmr; cpu_rd_idx = idx;
    @(negedge clk);
    cpu_rd_vld = 1'b0; cpu_rd_timer = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 5000);
      summary();
    end
  end

  initial begin
    for (int k = 0; k < NB; k++) codes[k] = 4'b0010;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 lock_vld", lock_vld, 0);
    chk("R11 hold_busy", hold_busy, 0);
    chk("R11 mv_grant", mv_grant, 0);
    chk("R11 overrun", overrun, 0);
    rst = 1'b0;

    for (int i = 0; i < 13; i++) begin
      automatic logic [VW-1:0] v = VEC[i];
      automatic string tag = $sformatf("R%0d vec%0d", v[3:0], i);
      codes[v[18:15]] = v[14:11];
      is_tx[v[18:15]] = v[10];
      compat_mode = v[9];
      cs_read(v[19], v[18:15]);
      chk({tag, " lock_vld"}, lock_vld, v[8]);
      if (v[8]) chk({tag, " lock_idx"}, lock_idx, v[7:4]);
    end
    compat_mode = 1'b1;

    // R7 unblocked move-in timing
    @(negedge clk); mv_req = 1'b1; mv_idx = 4'd3;
    @(negedge clk); mv_req = 1'b0;
    chk("R7 hold_busy", hold_busy, 1);
    chk("R7 no early grant", mv_grant, 0);
    @(negedge clk);
    chk("R7 grant", mv_grant, 1);
    chk("R7 grant idx", mv_grant_idx, 3);
    chk("R7 hold freed", hold_busy, 0);
    @(negedge clk);
    chk("R7 grant one cycle", mv_grant, 0);

    // R8 blocked, R10 overrun, R9 release timing
    codes[5] = 4'b0010;
    cs_read(1'b0, 4'd5);
    chk("R1 lock 5", lock_vld, 1);
    mv_req = 1'b1; mv_idx = 4'd5;
    @(negedge clk); mv_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 no grant", mv_grant, 0);
      chk("R8 still held", hold_busy, 1);
    end
    mv_req = 1'b1; mv_idx = 4'd9;
    @(negedge clk); mv_req = 1'b0;
    chk("R10 overrun", overrun, 1);
    @(negedge clk);
    chk("R10 overrun pulse", overrun, 0);
    chk("R8 no grant yet", mv_grant, 0);
    cpu_rd_vld = 1'b1; cpu_rd_timer = 1'b1;
    @(negedge clk); cpu_rd_vld = 1'b0; cpu_rd_timer = 1'b0;
    chk("R2 unlocked", lock_vld, 0);
    chk("R9 not same edge", mv_grant, 0);
    @(negedge clk);
    chk("R9 grant", mv_grant, 1);
    chk("R10 older idx", mv_grant_idx, 5);
    @(negedge clk);
    chk("R9 hold empty", hold_busy, 0);
    chk("R9 single grant", mv_grant, 0);
    summary();
  end
endmodule